// File: doc/BRIEF.md
# DMA Physical Address Generator for Byte and Word Channels

This block turns a channel's 16-bit current address, its 8-bit page and a channel-width setting into a 24-bit physical byte address. The generated addresses always fall in the lowest 16 MB of memory. A byte-wide channel uses 64K pages: the page supplies the top eight address bits and the 16-bit address supplies the rest. A word-wide channel uses 128K pages: the 16-bit address is shifted up by one bit, the least significant page bit is disregarded, and physical bit 0 is held at zero.

Software programs a transfer with a byte start address and a byte count. A load strobe converts these into register form. The address register receives the in-page offset, counted in words on a word channel. The count register receives the byte count minus one, halved on a word channel. A load is refused, and an error flag is raised, when the count is zero, when the transfer would run past the end of its page, or when a word channel is given an odd count or an odd start address. Each step strobe advances the address by one unit inside the page and decrements the count. An address that rolls over from 0xFFFF to 0x0000 leaves the page unchanged and pulses a wrap flag. A residue output reports the remaining transfer in bytes.

Top module: `dma_agen_top`

## Requirements
- R1: On a byte channel, phys_addr[23:16] equals the stored page and phys_addr[15:0] equals the stored 16-bit address.
- R2: On a word channel, phys_addr[23:17] equals page bits [7:1], phys_addr[16:1] equals the stored address, and phys_addr[0] is 0. Page bit 0 has no effect on the output.
- R3: An accepted load with width select 0 (byte) stores the address start_addr[15:0] and the count byte_count-1. With width select 1 (word) it stores the address start_addr[16:0]>>1 and the count (byte_count-1)>>1. In both cases the page is start_addr[23:16]. The stored count is visible on xfer_count one cycle after the load.
- R4: A step without a load advances the stored address by one (mod 2^16) and decrements the stored count by one (mod 2^16). Both changes are visible on the next cycle.
- R5: A step taken at address 0xFFFF wraps the address to 0x0000 and keeps the page. wrap_pulse is 1 for exactly the cycle after that step and is 0 at all other times.
- R6: A load is refused when byte_count is 0, when the page offset plus byte_count exceeds 65536 (byte) or 131072 (word), or when a word load has an odd byte_count or an odd start_addr. A refused load sets cfg_err and leaves the address, page, count and width unchanged. Any load updates cfg_err.
- R7: residue_bytes equals ((xfer_count+1) mod 2^16) on a byte channel and twice that value on a word channel.
- R8: byte_lanes is 2'b11 on a word channel. On a byte channel it is 2'b01 for an even address and 2'b10 for an odd address.
- R9: During and after a reset, the address, page and count are 0, the channel is byte-wide, and cfg_err and wrap_pulse are 0.
- R10: When load and step are both high in the same cycle, the load takes effect and the step is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Convert and store the software start address and count |
| width_sel | input | 1 | Channel width for a load: 0 byte, 1 word |
| start_addr | input | 24 | Software byte start address |
| byte_count | input | 18 | Software byte count |
| step | input | 1 | Advance one transfer unit |
| phys_addr | output | 24 | Physical byte address |
| byte_lanes | output | 2 | Active byte lanes of the current transfer |
| word_mode | output | 1 | Stored channel width: 1 word |
| wrap_pulse | output | 1 | Address rolled over within its page on the previous step |
| cfg_err | output | 1 | The last load was refused |
| xfer_count | output | 16 | Stored count in register form |
| residue_bytes | output | 17 | Remaining transfer in bytes |

## Verification
The bench first loads short transfers at page-interior addresses on both widths. These separate the byte mapping from the word mapping, and a start page with bit 0 set shows whether that bit leaks into a word address. It then loads transfers that end exactly at a page top and steps past the top. This distinguishes a wrap inside the page from a carry into the page, on 64K and on 128K pages. Refused loads are exercised one cause at a time: zero count, overrun by one, odd word count and odd word address. These show that each cause alone raises cfg_err and that the stored state is preserved. A run of random loads and steps, with load and step sometimes together, is compared on every cycle against a behavioural model. That run exercises precedence, count wrap and residue scaling.

// File: rtl/dma_agen_pkg.sv
// Shared types and sizes for the DMA physical address generator.
package dma_agen_pkg;
    typedef enum logic {
        CH_BYTE = 1'b0,
        CH_WORD = 1'b1
    } ch_width_e;

    localparam int unsigned AGEN_ADDR_W = 16;
    localparam int unsigned AGEN_PAGE_W = 8;
endpackage

// File: rtl/dma_agen_conv.sv
// Converts a software byte start address and byte count into register form.
// Also decides whether the request is legal.
// Assumes: inputs are sampled only while the load strobe is high. Pure combinational.
module dma_agen_conv
    import dma_agen_pkg::*;
#(
    parameter int unsigned ADDR_W = AGEN_ADDR_W,
    parameter int unsigned PAGE_W = AGEN_PAGE_W,
    localparam int unsigned PHYS_W = ADDR_W + PAGE_W,
    localparam int unsigned BCNT_W = ADDR_W + 2
) (
    input  ch_width_e          width,
    input  logic [PHYS_W-1:0]  start_addr,
    input  logic [BCNT_W-1:0]  byte_count,
    output logic [ADDR_W-1:0]  reg_addr,
    output logic [PAGE_W-1:0]  reg_page,
    output logic [ADDR_W-1:0]  reg_count,
    output logic               bad
);
    logic [BCNT_W-1:0] page_off;
    logic [BCNT_W:0]   end_off;
    logic [BCNT_W:0]   page_limit;
    logic [ADDR_W:0]   cnt_m1;
    logic              is_zero, overruns, misaligned;

    // Offset of the start address within its page, in bytes.
    always_comb begin
        if (width == CH_WORD) page_off = {1'b0, start_addr[ADDR_W:0]};
        else                  page_off = {2'b00, start_addr[ADDR_W-1:0]};
    end

    // Page size in bytes for the selected width.
    always_comb begin
        page_limit = '0;
        if (width == CH_WORD) page_limit[ADDR_W+1] = 1'b1;
        else                  page_limit[ADDR_W]   = 1'b1;
    end

    // Legality checks: zero count, page overrun, word misalignment.
    always_comb begin
        end_off    = {1'b0, page_off} + {1'b0, byte_count};
        is_zero    = (byte_count == '0);
        overruns   = (end_off > page_limit);
        misaligned = (width == CH_WORD) && (byte_count[0] || start_addr[0]);
        bad        = is_zero || overruns || misaligned;
    end

    // Register-form address, page and count.
    always_comb begin
        cnt_m1   = byte_count[ADDR_W:0] - 1'b1;
        reg_page = start_addr[PHYS_W-1:ADDR_W];
        if (width == CH_WORD) begin
            reg_addr  = start_addr[ADDR_W:1];
            reg_count = cnt_m1[ADDR_W:1];
        end else begin
            reg_addr  = start_addr[ADDR_W-1:0];
            reg_count = cnt_m1[ADDR_W-1:0];
        end
    end
endmodule

// File: rtl/dma_agen_state.sv
// Holds the channel's address, page, count and width.
// It advances them on each step and records load errors and in-page wraps.
// Assumes: load has precedence over step. A refused load changes only the error flag.
module dma_agen_state
    import dma_agen_pkg::*;
#(
    parameter int unsigned ADDR_W = AGEN_ADDR_W,
    parameter int unsigned PAGE_W = AGEN_PAGE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  ch_width_e          ld_width,
    input  logic [ADDR_W-1:0]  ld_addr,
    input  logic [PAGE_W-1:0]  ld_page,
    input  logic [ADDR_W-1:0]  ld_count,
    input  logic               ld_bad,
    output ch_width_e          cur_width,
    output logic [ADDR_W-1:0]  cur_addr,
    output logic [PAGE_W-1:0]  cur_page,
    output logic [ADDR_W-1:0]  cur_count,
    output logic               err_q,
    output logic               wrap_q
);
    localparam logic [ADDR_W-1:0] ADDR_TOP = '1;

    logic take_load, take_step;

    // Decode which update applies this cycle.
    always_comb begin
        take_load = load && !ld_bad;
        take_step = step && !load;
    end

    // Address, page, count and width registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_width <= CH_BYTE;
            cur_addr  <= '0;
            cur_page  <= '0;
            cur_count <= '0;
        end else if (take_load) begin
            cur_width <= ld_width;
            cur_addr  <= ld_addr;
            cur_page  <= ld_page;
            cur_count <= ld_count;
        end else if (take_step) begin
            cur_addr  <= cur_addr + 1'b1;
            cur_count <= cur_count - 1'b1;
        end
    end

    // Error flag follows the outcome of the latest load.
    always_ff @(posedge clk) begin
        if (!rst_n)    err_q <= 1'b0;
        else if (load) err_q <= ld_bad;
    end

    // One-cycle pulse after a step taken from the top of the page.
    always_ff @(posedge clk) begin
        if (!rst_n) wrap_q <= 1'b0;
        else        wrap_q <= take_step && (cur_addr == ADDR_TOP);
    end
endmodule

// File: rtl/dma_agen_map.sv
// Maps the stored state to the physical byte address, the byte lanes and the residue.
// Assumes: physical space is PAGE_W+ADDR_W bits wide. Pure combinational.
module dma_agen_map
    import dma_agen_pkg::*;
#(
    parameter int unsigned ADDR_W = AGEN_ADDR_W,
    parameter int unsigned PAGE_W = AGEN_PAGE_W,
    localparam int unsigned PHYS_W = ADDR_W + PAGE_W
) (
    input  ch_width_e          width,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [PAGE_W-1:0]  page,
    input  logic [ADDR_W-1:0]  count,
    output logic [PHYS_W-1:0]  phys,
    output logic [1:0]         lanes,
    output logic [ADDR_W:0]    residue
);
    logic [ADDR_W-1:0] units_left;

    // Physical address; a word channel drops page bit 0 and forces bit 0 low.
    always_comb begin
        if (width == CH_WORD) phys = {page[PAGE_W-1:1], addr, 1'b0};
        else                  phys = {page, addr};
    end

    // Byte lanes taking part in the current transfer.
    always_comb begin
        if (width == CH_WORD) lanes = 2'b11;
        else                  lanes = addr[0] ? 2'b10 : 2'b01;
    end

    // Remaining bytes, with the count's 16-bit wrap on the +1.
    always_comb begin
        units_left = count + 1'b1;
        if (width == CH_WORD) residue = {units_left, 1'b0};
        else                  residue = {1'b0, units_left};
    end
endmodule

// File: rtl/dma_agen_top.sv
// DMA physical address generator for byte and word channels.
// Converts a software request on load, steps within the page, and exposes the physical address.
// Assumes: a single channel context; register decode and arbitration live outside.
module dma_agen_top
    import dma_agen_pkg::*;
#(
    parameter int unsigned ADDR_W = AGEN_ADDR_W,
    parameter int unsigned PAGE_W = AGEN_PAGE_W,
    localparam int unsigned PHYS_W = ADDR_W + PAGE_W,
    localparam int unsigned BCNT_W = ADDR_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               width_sel,
    input  logic [PHYS_W-1:0]  start_addr,
    input  logic [BCNT_W-1:0]  byte_count,
    input  logic               step,
    output logic [PHYS_W-1:0]  phys_addr,
    output logic [1:0]         byte_lanes,
    output logic               word_mode,
    output logic               wrap_pulse,
    output logic               cfg_err,
    output logic [ADDR_W-1:0]  xfer_count,
    output logic [ADDR_W:0]    residue_bytes
);
    ch_width_e         ld_width, cur_width;
    logic [ADDR_W-1:0] ld_addr, ld_count, cur_addr, cur_count;
    logic [PAGE_W-1:0] ld_page, cur_page;
    logic              ld_bad;

    // Width select as the enumerated type.
    always_comb ld_width = width_sel ? CH_WORD : CH_BYTE;

    dma_agen_conv #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_conv (
        .width      (ld_width),
        .start_addr (start_addr),
        .byte_count (byte_count),
        .reg_addr   (ld_addr),
        .reg_page   (ld_page),
        .reg_count  (ld_count),
        .bad        (ld_bad)
    );

    dma_agen_state #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .ld_width  (ld_width),
        .ld_addr   (ld_addr),
        .ld_page   (ld_page),
        .ld_count  (ld_count),
        .ld_bad    (ld_bad),
        .cur_width (cur_width),
        .cur_addr  (cur_addr),
        .cur_page  (cur_page),
        .cur_count (cur_count),
        .err_q     (cfg_err),
        .wrap_q    (wrap_pulse)
    );

    dma_agen_map #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_map (
        .width   (cur_width),
        .addr    (cur_addr),
        .page    (cur_page),
        .count   (cur_count),
        .phys    (phys_addr),
        .lanes   (byte_lanes),
        .residue (residue_bytes)
    );

    // Expose the stored width and count.
    always_comb begin
        word_mode  = (cur_width == CH_WORD);
        xfer_count = cur_count;
    end
endmodule

// File: rtl/dma_agen_checker.sv
// Temporal checks on the address generator's ports, attached with bind.
module dma_agen_checker #(
    parameter int unsigned PHYS_W = 24,
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load,
    input logic              step,
    input logic [PHYS_W-1:0] phys_addr,
    input logic [1:0]        byte_lanes,
    input logic              word_mode,
    input logic              wrap_pulse,
    input logic              cfg_err,
    input logic [ADDR_W-1:0] xfer_count
);
    // R2: word addresses are always even
    a_r2_word_even: assert property (@(posedge clk) disable iff (!rst_n)
        word_mode |-> (phys_addr[0] == 1'b0));

    // R4: a lone byte step advances the low address by one and the count down by one
    a_r4_byte_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !word_mode) |=>
            (phys_addr[15:0] == $past(phys_addr[15:0]) + 16'd1) &&
            (xfer_count == $past(xfer_count) - 16'd1));

    // R5: the page bits never move on a step
    a_r5_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (phys_addr[PHYS_W-1:17] == $past(phys_addr[PHYS_W-1:17])));

    // R5: the wrap flag lasts a single cycle
    a_r5_wrap_single: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |=> !wrap_pulse);

    // R6: a refused load keeps the address
    a_r6_refused_hold: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!cfg_err || (phys_addr == $past(phys_addr))));

    // R8: a byte channel drives exactly one lane
    a_r8_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        !word_mode |-> ($countones(byte_lanes) == 1));

    // R10: load together with step never produces a wrap
    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (load && step) |=> !wrap_pulse);
endmodule

bind dma_agen_top dma_agen_checker #(.PHYS_W(PHYS_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .step       (step),
    .phys_addr  (phys_addr),
    .byte_lanes (byte_lanes),
    .word_mode  (word_mode),
    .wrap_pulse (wrap_pulse),
    .cfg_err    (cfg_err),
    .xfer_count (xfer_count)
);

// File: tb/dma_agen_top_bench.sv
`timescale 1ns/100ps
module dma_agen_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic        width_sel = 1'b0;
    logic [23:0] start_addr = '0;
    logic [17:0] byte_count = '0;
    logic        step = 1'b0;
    logic [23:0] phys_addr;
    logic [1:0]  byte_lanes;
    logic        word_mode, wrap_pulse, cfg_err;
    logic [15:0] xfer_count;
    logic [16:0] residue_bytes;

    int vectors = 0;
    int miscompares = 0;

    // model state
    int m_word = 0, m_addr = 0, m_page = 0, m_cnt = 0, m_err = 0, m_wrap = 0;

    always #2.5 clk = ~clk;

    dma_agen_top u_dma_agen_top (
        .clk(clk), .rst_n(rst_n), .load(load), .width_sel(width_sel),
        .start_addr(start_addr), .byte_count(byte_count), .step(step),
        .phys_addr(phys_addr), .byte_lanes(byte_lanes), .word_mode(word_mode),
        .wrap_pulse(wrap_pulse), .cfg_err(cfg_err), .xfer_count(xfer_count),
        .residue_bytes(residue_bytes)
    );

    // Behavioural reference model, updated on each rising edge
    always @(posedge clk) begin
        int off, lim, cnt_i, st;
        if (!rst_n) begin
            m_word = 0; m_addr = 0; m_page = 0; m_cnt = 0; m_err = 0; m_wrap = 0;
        end else if (load) begin
            int bad;
            st    = int'(start_addr);
            cnt_i = int'(byte_count);
            off   = width_sel ? (st % 131072) : (st % 65536);
            lim   = width_sel ? 131072 : 65536;
            bad   = (cnt_i == 0) || (off + cnt_i > lim) ||
                    (width_sel && ((cnt_i % 2) != 0 || (st % 2) != 0));
            m_err  = bad;
            m_wrap = 0;
            if (!bad) begin
                m_word = width_sel;
                m_page = st / 65536;
                m_addr = width_sel ? (off / 2) : off;
                m_cnt  = width_sel ? ((cnt_i - 1) / 2) % 65536 : (cnt_i - 1) % 65536;
            end
        end else if (step) begin
            m_wrap = (m_addr == 65535);
            m_addr = (m_addr + 1) % 65536;
            m_cnt  = (m_cnt + 65535) % 65536;
        end else begin
            m_wrap = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare outputs against the model at every falling edge
    always @(negedge clk) begin
        int e_phys, e_lanes, e_res;
        e_phys  = m_word ? ((m_page / 2) * 131072 + m_addr * 2) : (m_page * 65536 + m_addr);
        e_lanes = m_word ? 3 : ((m_addr % 2) ? 2 : 1);
        e_res   = ((m_cnt + 1) % 65536) * (m_word ? 2 : 1);
        chk(m_word ? "R2 word address" : "R1 byte address", int'(phys_addr), e_phys);
        chk("R8 lanes", int'(byte_lanes), e_lanes);
        chk("R5 wrap pulse", int'(wrap_pulse), m_wrap);
        chk("R6 error flag", int'(cfg_err), m_err);
        chk("R3 count", int'(xfer_count), m_cnt);
        chk("R7 residue", int'(residue_bytes), e_res);
        chk("R9 width", int'(word_mode), m_word);
    end

    task automatic cyc(input logic ld, input logic wd, input int sa, input int bc, input logic st);
        @(negedge clk);
        load = ld; width_sel = wd; start_addr = 24'(sa); byte_count = 18'(bc); step = st;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 0, 0, 1'b1);
    endtask

    initial begin
        #(5.0 * 150000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) cyc(1'b0, 1'b0, 0, 0, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        // R1 R3 R4: byte load and steps
        cyc(1'b1, 1'b0, 'h123456, 16, 1'b0);
        steps(5);
        // R2: word load, page bit 0 set, walk across the 128K top (R5)
        cyc(1'b1, 1'b1, 'h35FFF0, 16, 1'b0);
        steps(10);
        // R5: byte wrap at 64K top
        cyc(1'b1, 1'b0, 'h07FFFE, 2, 1'b0);
        steps(4);
        cyc(1'b0, 1'b0, 0, 0, 1'b0);
        // R6: refused loads, one cause each
        cyc(1'b1, 1'b0, 'h200000, 0, 1'b0);
        cyc(1'b1, 1'b0, 'h20FFFF, 2, 1'b0);
        cyc(1'b1, 1'b1, 'h300000, 3, 1'b0);
        cyc(1'b1, 1'b1, 'h300001, 4, 1'b0);
        cyc(1'b1, 1'b1, 'h310000, 131072, 1'b0);
        // R3: full-size transfers, R7 residue wrap
        cyc(1'b1, 1'b0, 'h100000, 65536, 1'b0);
        steps(3);
        cyc(1'b1, 1'b1, 'h400000, 131072, 1'b0);
        steps(3);
        // R10: load and step together
        cyc(1'b1, 1'b0, 'h00ABCD, 8, 1'b1);
        cyc(1'b0, 1'b0, 0, 0, 1'b0);
        // R9: reset mid-run
        cyc(1'b0, 1'b0, 0, 0, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        cyc(1'b0, 1'b0, 0, 0, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic ld, wd, st;
            int sa, bc;
            ld = ($urandom % 10) == 0;
            wd = $urandom % 2;
            st = ($urandom % 3) != 0;
            sa = int'($urandom % 24'hFFFFFF);
            if ($urandom % 2) sa = sa | 'hFFF0;
            bc = int'($urandom % 40);
            cyc(ld, wd, sa, bc, st);
        end
        cyc(1'b0, 1'b0, 0, 0, 1'b0);
        @(negedge clk);
        @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule